// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block sits on the host side of a parallel NOR-style flash bus. It takes one program or erase request at a time. It issues the protected unlock-and-command write sequence for that request. It then decides when the flash has finished, using one of three methods:

- watching a status bit that flips on every read while the flash is busy;
- comparing a data bit against the value the flash will show once it is done;
- waiting a fixed, parameterised worst-case time.

A status read can land on the exact cycle the flash finishes, so one passing read is not trusted. After any apparent completion the block reads the same location twice more. It reports success only if both of those reads return the expected final word. A safety limit a little beyond the worst-case operation time ends polling with a timeout status.

The flash side is a simple synchronous bus. A write is a one-cycle strobe with address and data valid on that cycle. A read is a one-cycle strobe, after which the address is held and the data is sampled a parameterised number of cycles later.

The controller is a single state machine with seven states:

- `S_IDLE` waits for a request. It moves to `S_WRITE` on acceptance.
- `S_WRITE` issues one command word per cycle. After the last word it moves to `S_TIMER` for the timer method, or to `S_RSTRB` for the other two.
- `S_TIMER` waits until the fixed time has passed, then moves to `S_RSTRB`.
- `S_RSTRB` issues the read strobe, then moves to `S_RWAIT`.
- `S_RWAIT` counts the read wait cycles and captures the data into `S_CHECK`.
- `S_CHECK` judges the read. It goes back to `S_RSTRB` to keep polling, or to confirm. It goes to `S_REPORT` on a confirm mismatch, on the second good confirm read, or on timeout.
- `S_REPORT` pulses done for one cycle, then returns to `S_IDLE`.

Top module: `fwc_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, and `done_o`, `fl_we` and `fl_re` are 0 until a request is accepted.
- R2: A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle through the `done_o` cycle and high on the cycle after it. Requests presented while busy are not accepted and cause no bus write.
- R3: Operation code 0 is a word program. It gives four consecutive write strobes starting the cycle after acceptance, with data in bits 7:0 and zero above for the three command words:
  - (0x5555, 0xAA)
  - (0x2AAA, 0x55)
  - (0x5555, 0xA0)
  - (request address, request data)
  
  The bus address is {bank bit, 18-bit word address}, with the bank bit as the most significant bit on every cycle.
- R4: Operation codes 1, 2 and 3 are sector, block and whole-bank erase. Each gives six consecutive write strobes. The first five are (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55). The sixth carries the region address and a code:
  - sector: the request address with its low 10 bits cleared, code 0x30;
  - block: the request address with its low 15 bits cleared, code 0x50;
  - whole bank: address 0x5555, code 0x10.
- R5: The block issues no read strobe before the final command write and never strobes write and read together. Each read strobe lasts one cycle, the address is held on the following cycle, and data is sampled `RD_WAIT` cycles after the strobe. Every status read targets the address of the final command write.
- R6: With method code 0 (toggle), a read indicates apparent completion when its bit 6 equals bit 6 of the previous read of the same request.
- R7: With method code 1 (data polling), a read indicates apparent completion when its bit 7 equals the expected bit. The expected bit is bit 7 of the program data, or 1 for any erase.
- R8: With method codes 2 and 3 (timer), no read occurs until exactly T cycles after the final command write, where T is `T_PROG`, `T_SECT`, `T_BLK` or `T_BANK` by operation. The first read strobe falls on that cycle.
- R9: After apparent completion, or the timer expiring, exactly two confirm reads follow. Each must equal the expected word, which is the program data or 0xFFFF for an erase. The status is 0 (success) if both match. It is 1 (fail) at the first mismatch, and no further read is issued after a mismatch.
- R10: For methods 0 and 1, a read that does not show completion is judged at least TMO cycles after the final command write, where TMO = T + T/4 + 8. In that case the status is 2 (timeout).
- R11: `done_o` is a one-cycle pulse exactly `RD_WAIT` + 2 cycles after the strobe of the deciding read. `status_o` is valid on that cycle and is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 bank erase |
| req_method | input | 2 | 0 toggle, 1 data polling, 2 or 3 fixed timer |
| req_bank | input | 1 | Target bank |
| req_addr | input | AW | Word address inside the bank |
| req_data | input | DW | Program data |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 success, 1 fail, 2 timeout (valid with done_o) |
| fl_addr | output | AW+1 | Flash bus address, bank bit on top |
| fl_wdata | output | DW | Flash bus write data |
| fl_we | output | 1 | One-cycle write strobe |
| fl_re | output | 1 | One-cycle read strobe |
| fl_rdata | input | DW | Flash bus read data |

## Verification
The assertions check the cycle-level bus rules on every cycle:
- the write and read strobes never overlap;
- each read strobe lasts one cycle, with its address held on the next;
- done is a single pulse with a legal status, followed by ready;
- every acceptance is followed at once by the first unlock write.

Only the bench's scenarios can show the decisions that depend on what the flash returns. These are the toggle and polling detection points, the exact timer delay, the two-read confirmation with its fail path, and the timeout limit. The bench shows them by driving busy, finishing, corrupted and never-finishing flash responses and predicting each read and the done cycle.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_BANK = 2'd3
    } fwc_op_e;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_FAIL = 2'd1,
        RES_TMO  = 2'd2
    } fwc_res_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_TIMER,
        S_RSTRB,
        S_RWAIT,
        S_CHECK,
        S_REPORT
    } fwc_state_e;

    localparam logic [7:0] KEY_A     = 8'hAA;
    localparam logic [7:0] KEY_B     = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CODE_SECT = 8'h30;
    localparam logic [7:0] CODE_BLK  = 8'h50;
    localparam logic [7:0] CODE_BANK = 8'h10;

    localparam logic [14:0] UNLOCK_HI = 15'h5555;
    localparam logic [14:0] UNLOCK_LO = 15'h2AAA;

endpackage

// File: rtl/fwc_cmd_gen.sv
module fwc_cmd_gen
    import fwc_pkg::*;
#(
    parameter int AW      = 18,
    parameter int DW      = 16,
    parameter int SEC_LSB = 10,
    parameter int BLK_LSB = 15
) (
    input  fwc_op_e         op,
    input  logic [2:0]      step,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   data,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic            last_step,
    output logic [AW-1:0]   poll_addr,
    output logic [DW-1:0]   exp_word
);

    localparam logic [AW-1:0] SEC_MASK = ~((AW'(1) << SEC_LSB) - AW'(1));
    localparam logic [AW-1:0] BLK_MASK = ~((AW'(1) << BLK_LSB) - AW'(1));
    localparam logic [AW-1:0] A_HI     = AW'(UNLOCK_HI);
    localparam logic [AW-1:0] A_LO     = AW'(UNLOCK_LO);

    logic          is_prog;
    logic [AW-1:0] region;
    logic [7:0]    code;

    assign is_prog = (op == OP_PROG);

    always_comb begin
        unique case (op)
            OP_SECT: begin region = addr & SEC_MASK; code = CODE_SECT; end
            OP_BLK:  begin region = addr & BLK_MASK; code = CODE_BLK;  end
            OP_BANK: begin region = A_HI;            code = CODE_BANK; end
            default: begin region = addr;            code = CMD_PROG;  end
        endcase
    end

    assign poll_addr = region;
    assign exp_word  = is_prog ? data : '1;
    assign last_step = is_prog ? (step == 3'd3) : (step == 3'd5);

    always_comb begin
        unique case (step)
            3'd0: begin wr_addr = A_HI; wr_data = DW'(KEY_A); end
            3'd1: begin wr_addr = A_LO; wr_data = DW'(KEY_B); end
            3'd2: begin
                wr_addr = A_HI;
                wr_data = is_prog ? DW'(CMD_PROG) : DW'(CMD_ERASE);
            end
            3'd3: begin
                wr_addr = is_prog ? addr : A_HI;
                wr_data = is_prog ? data : DW'(KEY_A);
            end
            3'd4: begin wr_addr = A_LO; wr_data = DW'(KEY_B); end
            default: begin wr_addr = region; wr_data = DW'(code); end
        endcase
    end

endmodule

// File: rtl/fwc_elapsed.sv
module fwc_elapsed #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] wait_lim,
    input  logic [CW-1:0] tmo_lim,
    output logic          wait_hit,
    output logic          tmo_hit
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CW'(1);
        end else if (cnt != '1) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign wait_hit = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, wait_lim};
    assign tmo_hit  = cnt >= tmo_lim;

endmodule

// File: rtl/fwc_status_eval.sv
module fwc_status_eval #(
    parameter int DW = 16
) (
    input  logic [1:0]    method,
    input  logic [DW-1:0] word,
    input  logic [DW-1:0] exp_word,
    input  logic          prev_dq6,
    input  logic          have_prev,
    output logic          seen_done,
    output logic          word_ok
);

    always_comb begin
        unique case (method)
            2'd0:    seen_done = have_prev && (word[6] == prev_dq6);
            2'd1:    seen_done = (word[7] == exp_word[7]);
            default: seen_done = 1'b1;
        endcase
    end

    assign word_ok = (word == exp_word);

endmodule

// File: rtl/fwc_ctrl.sv
module fwc_ctrl
    import fwc_pkg::*;
#(
    parameter int AW      = 18,
    parameter int DW      = 16,
    parameter int SEC_LSB = 10,
    parameter int BLK_LSB = 15,
    parameter int RD_WAIT = 2,
    parameter int T_PROG  = 24,
    parameter int T_SECT  = 120,
    parameter int T_BLK   = 200,
    parameter int T_BANK  = 400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_method,
    input  logic          req_bank,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          done_o,
    output logic [1:0]    status_o,
    output logic [AW:0]   fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          fl_we,
    output logic          fl_re,
    input  logic [DW-1:0] fl_rdata
);

    localparam int TMO_PROG = T_PROG + T_PROG / 4 + 8;
    localparam int TMO_SECT = T_SECT + T_SECT / 4 + 8;
    localparam int TMO_BLK  = T_BLK  + T_BLK  / 4 + 8;
    localparam int TMO_BANK = T_BANK + T_BANK / 4 + 8;
    localparam int TMAX_A   = (TMO_PROG > TMO_SECT) ? TMO_PROG : TMO_SECT;
    localparam int TMAX_B   = (TMO_BLK  > TMO_BANK) ? TMO_BLK  : TMO_BANK;
    localparam int TMAX     = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int CW       = $clog2(TMAX + 2) + 1;

    fwc_state_e state, state_nx;

    fwc_op_e       op_q;
    logic [1:0]    meth_q;
    logic          bank_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [2:0]    step_q;
    logic [DW-1:0] word_q;
    logic          prev_dq6_q;
    logic          have_prev_q;
    logic          conf_q;
    logic          conf_cnt_q;
    fwc_res_e      res_q;

    logic [AW-1:0] gen_addr;
    logic [DW-1:0] gen_data;
    logic          gen_last;
    logic [AW-1:0] poll_addr;
    logic [DW-1:0] exp_word;
    logic          seen_done;
    logic          word_ok;
    logic          wait_hit;
    logic          tmo_hit;
    logic          rd_last;
    logic [CW-1:0] wait_lim;
    logic [CW-1:0] tmo_lim;
    logic          restart;

    fwc_cmd_gen #(
        .AW(AW), .DW(DW), .SEC_LSB(SEC_LSB), .BLK_LSB(BLK_LSB)
    ) gen_i (
        .op        (op_q),
        .step      (step_q),
        .addr      (addr_q),
        .data      (data_q),
        .wr_addr   (gen_addr),
        .wr_data   (gen_data),
        .last_step (gen_last),
        .poll_addr (poll_addr),
        .exp_word  (exp_word)
    );

    fwc_status_eval #(.DW(DW)) eval_i (
        .method    (meth_q),
        .word      (word_q),
        .exp_word  (exp_word),
        .prev_dq6  (prev_dq6_q),
        .have_prev (have_prev_q),
        .seen_done (seen_done),
        .word_ok   (word_ok)
    );

    always_comb begin
        unique case (op_q)
            OP_SECT: begin wait_lim = CW'(T_SECT); tmo_lim = CW'(TMO_SECT); end
            OP_BLK:  begin wait_lim = CW'(T_BLK);  tmo_lim = CW'(TMO_BLK);  end
            OP_BANK: begin wait_lim = CW'(T_BANK); tmo_lim = CW'(TMO_BANK); end
            default: begin wait_lim = CW'(T_PROG); tmo_lim = CW'(TMO_PROG); end
        endcase
    end

    assign restart = (state == S_WRITE) && gen_last;

    fwc_elapsed #(.CW(CW)) elapsed_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .wait_lim (wait_lim),
        .tmo_lim  (tmo_lim),
        .wait_hit (wait_hit),
        .tmo_hit  (tmo_hit)
    );

    // Read wait counter: absent when a single wait cycle suffices.
    generate
        if (RD_WAIT <= 1) begin : g_rd_single
            assign rd_last = 1'b1;
        end else begin : g_rd_count
            localparam int RWW = $clog2(RD_WAIT + 1);
            logic [RWW-1:0] rdw_cnt;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rdw_cnt <= '0;
                end else if (state == S_RSTRB) begin
                    rdw_cnt <= RWW'(RD_WAIT - 1);
                end else if (state == S_RWAIT && rdw_cnt != '0) begin
                    rdw_cnt <= rdw_cnt - RWW'(1);
                end
            end
            assign rd_last = (rdw_cnt == '0);
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_WRITE;
            S_WRITE:  if (gen_last) state_nx = meth_q[1] ? S_TIMER : S_RSTRB;
            S_TIMER:  if (wait_hit) state_nx = S_RSTRB;
            S_RSTRB:  state_nx = S_RWAIT;
            S_RWAIT:  if (rd_last) state_nx = S_CHECK;
            S_CHECK: begin
                if (conf_q) begin
                    if (!word_ok || conf_cnt_q) state_nx = S_REPORT;
                    else                        state_nx = S_RSTRB;
                end else if (!seen_done && tmo_hit) begin
                    state_nx = S_REPORT;
                end else begin
                    state_nx = S_RSTRB;
                end
            end
            S_REPORT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Request and status datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= OP_PROG;
            meth_q      <= '0;
            bank_q      <= 1'b0;
            addr_q      <= '0;
            data_q      <= '0;
            step_q      <= '0;
            word_q      <= '0;
            prev_dq6_q  <= 1'b0;
            have_prev_q <= 1'b0;
            conf_q      <= 1'b0;
            conf_cnt_q  <= 1'b0;
            res_q       <= RES_OK;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q   <= fwc_op_e'(req_op);
                        meth_q <= req_method;
                        bank_q <= req_bank;
                        addr_q <= req_addr;
                        data_q <= req_data;
                        step_q <= '0;
                    end
                end
                S_WRITE: begin
                    step_q <= step_q + 3'd1;
                    if (gen_last) begin
                        have_prev_q <= 1'b0;
                        conf_q      <= meth_q[1];
                        conf_cnt_q  <= 1'b0;
                    end
                end
                S_RWAIT: begin
                    if (rd_last) word_q <= fl_rdata;
                end
                S_CHECK: begin
                    if (conf_q) begin
                        if (!word_ok)        res_q <= RES_FAIL;
                        else if (conf_cnt_q) res_q <= RES_OK;
                        else                 conf_cnt_q <= 1'b1;
                    end else begin
                        prev_dq6_q  <= word_q[6];
                        have_prev_q <= 1'b1;
                        if (seen_done)    conf_q <= 1'b1;
                        else if (tmo_hit) res_q  <= RES_TMO;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        done_o    = 1'b0;
        status_o  = 2'd0;
        fl_we     = 1'b0;
        fl_re     = 1'b0;
        fl_wdata  = '0;
        fl_addr   = {bank_q, poll_addr};
        unique case (state)
            S_IDLE:   req_ready = 1'b1;
            S_WRITE: begin
                fl_we    = 1'b1;
                fl_addr  = {bank_q, gen_addr};
                fl_wdata = gen_data;
            end
            S_RSTRB:  fl_re = 1'b1;
            S_REPORT: begin
                done_o   = 1'b1;
                status_o = res_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fwc_ctrl_chk.sv
module fwc_ctrl_chk #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done_o,
    input logic [1:0]    status_o,
    input logic [AW:0]   fl_addr,
    input logic [DW-1:0] fl_wdata,
    input logic          fl_we,
    input logic          fl_re
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!fl_we && !fl_re && !done_o));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && fl_we));

    // R3
    first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (fl_addr[14:0] == 15'h5555 && fl_wdata == DW'(8'hAA)));

    // R5
    no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re |=> !fl_re);

    // R5
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re |=> $stable(fl_addr));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && req_ready));

    // R11
    done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o != 2'b11 && !req_ready));

endmodule

bind fwc_ctrl fwc_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done_o    (done_o),
    .status_o  (status_o),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata),
    .fl_we     (fl_we),
    .fl_re     (fl_re)
);

// File: tb/fwc_ctrl_tb_top.sv
module fwc_ctrl_tb_top;

    localparam int AW = 18, DW = 16, RD_WAIT = 2;
    localparam int T_PROG = 24, T_SECT = 120, T_BLK = 200, T_BANK = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [1:0]    req_method = '0;
    logic          req_bank = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          done_o;
    logic [1:0]    status_o;
    logic [AW:0]   fl_addr;
    logic [DW-1:0] fl_wdata;
    logic          fl_we, fl_re;
    logic [DW-1:0] fl_rdata = '0;

    always #4 clk = ~clk;

    fwc_ctrl #(.AW(AW), .DW(DW), .RD_WAIT(RD_WAIT), .T_PROG(T_PROG),
               .T_SECT(T_SECT), .T_BLK(T_BLK), .T_BANK(T_BANK)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_method(req_method), .req_bank(req_bank),
        .req_addr(req_addr), .req_data(req_data), .done_o(done_o),
        .status_o(status_o), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Flash response knobs
    int busy_len = 0;
    bit never_done = 0;
    int corrupt_at = -1;

    // Reference model state
    logic [AW:0]   wq_addr[$];
    logic [DW-1:0] wq_data[$];
    int cur_op, cur_meth, cur_T, cur_TMO;
    logic [DW-1:0] cur_exp;
    logic [AW:0]   cur_poll;
    bit seq_done = 0, first_rd = 0, phase_conf = 0, have_prev = 0, tog = 0, busy_m = 0;
    logic prev6 = 0;
    int conf_left = 0, post_reads = 0, exp_done = -1, exp_status = 0;
    int acc_cnt = 0, done_cnt = 0, last_status = 0, last_wr = 0;

    task automatic push_wr(logic b, logic [AW-1:0] a, logic [DW-1:0] d);
        wq_addr.push_back({b, a});
        wq_data.push_back(d);
    endtask

    task automatic on_accept();
        logic [AW-1:0] reg_a;
        logic [7:0] code;
        cur_op = int'(req_op);
        cur_meth = int'(req_method);
        push_wr(req_bank, 18'h05555, 16'h00AA);
        push_wr(req_bank, 18'h02AAA, 16'h0055);
        if (cur_op == 0) begin
            push_wr(req_bank, 18'h05555, 16'h00A0);
            push_wr(req_bank, req_addr, req_data);
            cur_exp = req_data;
            cur_poll = {req_bank, req_addr};
            cur_T = T_PROG;
        end else begin
            case (cur_op)
                1: begin reg_a = req_addr & ~18'h003FF; code = 8'h30; cur_T = T_SECT; end
                2: begin reg_a = req_addr & ~18'h07FFF; code = 8'h50; cur_T = T_BLK; end
                default: begin reg_a = 18'h05555; code = 8'h10; cur_T = T_BANK; end
            endcase
            push_wr(req_bank, 18'h05555, 16'h0080);
            push_wr(req_bank, 18'h05555, 16'h00AA);
            push_wr(req_bank, 18'h02AAA, 16'h0055);
            push_wr(req_bank, reg_a, {8'h00, code});
            cur_exp = 16'hFFFF;
            cur_poll = {req_bank, reg_a};
        end
        cur_TMO = cur_T + cur_T / 4 + 8;
        seq_done = 0; first_rd = 0; have_prev = 0; tog = 0;
        phase_conf = (cur_meth >= 2);
        conf_left = 2; post_reads = 0; exp_done = -1;
    endtask

    function automatic string mtag();
        if (cur_meth == 0) return "R6";
        if (cur_meth == 1) return "R7";
        return "R8";
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [DW-1:0] w;
            bit complete;
            // R2: ready tracks the model's idle state
            chk(req_ready == !busy_m, "R2 ready", req_ready, !busy_m);
            if (fl_we && fl_re) chk(0, "R5 write/read overlap", 1, 0);
            if (fl_we) begin
                if (wq_addr.size() == 0) begin
                    chk(0, "R2 unexpected bus write", fl_addr, 0);
                end else begin
                    logic [AW:0] ea;
                    logic [DW-1:0] ed;
                    ea = wq_addr.pop_front();
                    ed = wq_data.pop_front();
                    chk(fl_addr == ea, (cur_op == 0) ? "R3 write addr" : "R4 write addr", fl_addr, ea);
                    chk(fl_wdata == ed, (cur_op == 0) ? "R3 write data" : "R4 write data", fl_wdata, ed);
                    if (wq_addr.size() == 0) begin
                        seq_done = 1;
                        last_wr = cyc;
                    end
                end
            end
            if (fl_re) begin
                if (!seq_done) chk(0, "R5 read before final write", cyc, last_wr);
                chk(fl_addr == cur_poll, "R5 read addr", fl_addr, cur_poll);
                if (cur_meth >= 2 && !first_rd)
                    chk(cyc == last_wr + cur_T, "R8 timer first read", cyc - last_wr, cur_T);
                first_rd = 1;
                if (exp_done != -1) chk(0, "R9 read after decision", cyc, exp_done);
                if (!never_done && cyc >= last_wr + busy_len) begin
                    w = cur_exp;
                    if (post_reads == corrupt_at) w = w ^ 16'h0100;
                    post_reads++;
                end else begin
                    w = {cur_exp[15:8], ~cur_exp[7], tog, cur_exp[5:0]};
                    tog = ~tog;
                end
                fl_rdata <= w;
                if (phase_conf) begin
                    if (w != cur_exp) begin
                        exp_done = cyc + RD_WAIT + 2; exp_status = 1;
                    end else begin
                        conf_left--;
                        if (conf_left == 0) begin
                            exp_done = cyc + RD_WAIT + 2; exp_status = 0;
                        end
                    end
                end else begin
                    complete = (cur_meth == 0) ? (have_prev && w[6] == prev6) : (w[7] == cur_exp[7]);
                    have_prev = 1;
                    prev6 = w[6];
                    if (complete) phase_conf = 1;
                    else if (cyc + RD_WAIT + 1 - last_wr >= cur_TMO) begin
                        exp_done = cyc + RD_WAIT + 2; exp_status = 2;
                    end
                end
            end
            if (done_o) begin
                string t;
                t = (exp_status == 2) ? "R10" : "R9";
                chk(cyc == exp_done, {"R11/", mtag(), " done cycle"}, cyc, exp_done);
                chk(int'(status_o) == exp_status, {t, "/", mtag(), " status"}, status_o, exp_status);
                last_status = int'(status_o);
                busy_m = 0;
                exp_done = -1;
                done_cnt++;
            end else if (exp_done == cyc) begin
                chk(0, "R11 missing done", 0, 1);
                exp_done = -1;
            end
            if (req_valid && req_ready) begin
                on_accept();
                busy_m = 1;
                acc_cnt++;
            end
        end
    end

    task automatic run_req(int op, int meth, bit bank, logic [AW-1:0] addr, logic [DW-1:0] data,
                           int busy, bit nodone, int corrupt, int hold, int want, string tag);
        int a0, d0, guard;
        @(posedge clk); #1;
        busy_len = busy; never_done = nodone; corrupt_at = corrupt;
        req_op = op[1:0]; req_method = meth[1:0]; req_bank = bank;
        req_addr = addr; req_data = data;
        a0 = acc_cnt; d0 = done_cnt;
        req_valid = 1'b1;
        guard = 0;
        while (acc_cnt == a0 && guard < 100) begin @(posedge clk); #1; guard++; end
        repeat (hold) begin @(posedge clk); #1; end
        req_valid = 1'b0;
        guard = 0;
        while (done_cnt == d0 && guard < 5000) begin @(posedge clk); #1; guard++; end
        if (done_cnt == d0) chk(0, {tag, " no done"}, 0, 1);
        else if (want >= 0) chk(last_status == want, {tag, " scenario status"}, last_status, want);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(!fl_we && !fl_re, "R1 strobes idle", {fl_we, fl_re}, 0);
        chk(done_o == 1'b0, "R1 done low", done_o, 0);
        repeat (3) @(posedge clk);

        run_req(0, 0, 0, 18'h0ABCD, 16'h1234, 30, 0, -1, 0, 0, "R6 program toggle");
        run_req(0, 1, 0, 18'h01000, 16'h00F5, 30, 0, -1, 0, 0, "R7 program poll bit7=1");
        run_req(0, 1, 1, 18'h3FFFF, 16'h3A21, 30, 0, -1, 0, 0, "R7 program poll bit7=0");
        run_req(1, 1, 1, 18'h257FF, 16'h0000, 60, 0, -1, 0, 0, "R4 sector erase poll");
        run_req(2, 0, 0, 18'h39001, 16'h0000, 80, 0, -1, 0, 0, "R4 block erase toggle");
        run_req(3, 2, 1, 18'h12345, 16'h0000, 300, 0, -1, 0, 0, "R8 bank erase timer");
        run_req(0, 2, 0, 18'h00042, 16'hBEEF, 20, 0, -1, 0, 0, "R8 program timer");
        run_req(0, 1, 0, 18'h00777, 16'h5A5A, 30, 0, 1, 0, 1, "R9 first confirm fails");
        run_req(0, 0, 0, 18'h0ABCD, 16'h1234, 30, 0, 3, 0, 1, "R9 second confirm fails");
        run_req(0, 2, 1, 18'h00100, 16'hC3C3, 100, 0, -1, 0, 1, "R9 timer still busy");
        run_req(0, 1, 0, 18'h00200, 16'h0081, 0, 1, -1, 0, 2, "R10 poll timeout");
        run_req(1, 0, 1, 18'h10400, 16'h0000, 0, 1, -1, 0, 2, "R10 toggle timeout");
        run_req(0, 1, 0, 18'h00300, 16'h7E01, 30, 0, -1, 12, 0, "R2 request held while busy");
        run_req(2, 3, 0, 18'h08000, 16'h0000, 50, 0, -1, 0, 0, "R8 timer alias code");
        run_req(0, 1, 1, 18'h00001, 16'hFFFF, 0, 0, -1, 0, 0, "R7 immediate completion");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule